// File: doc/BRIEF.md
# Converter Host Bus Control

This block is the host-facing control logic of a 12-bit successive-approximation converter. It watches five host control lines: an active-high chip enable, an active-low chip select, a read/convert line, a combined length-select/byte-address line and a word/byte data-mode line. From them it decides when a conversion begins, and it tells the sequencer how long that conversion is. It also decides which part of the finished result is presented to the host and when.

The sequencer is outside this block. It receives a one-cycle start pulse and a latched length flag, reports `busy_i` while it works, and supplies the result word.

On the host side the parallel bus is modelled without tri-state drivers. There is a 12-bit word output and an 8-bit byte-lane output, each with its own enable. The byte lane carries either the upper eight result bits or the lower four result bits padded with zeros.

The same logic also serves a stand-alone arrangement. In that arrangement the host ties off every control line except read/convert and drives that one line alone.

Top module: `adc_host_ctrl`

## Requirements
- R1: A conversion start occurs when chip enable is 1, chip select is 0 and read/convert is 0 at the same time. Whichever of the three lines completes that condition acts as the trigger. Lines that change together produce exactly one start. No start occurs while any one of the three lines is inactive.
- R2: At each start, `short_cyc_o` takes the value of `addr_short_i` (1 = 8-bit conversion, 0 = 12-bit conversion). It keeps that value until the next start.
- R3: From a start until `busy_i` falls, every output enable stays 0. Any start condition that arises in that window is ignored, even if it is still present after `busy_i` falls.
- R4: The output enables can be 1 only when read/convert is 1, chip enable is 1, chip select is 0 and no conversion is in progress.
- R5: When `wide_i` is 1 and a read is allowed, `word_oe_o` is 1 and `data_o` equals the full result, whatever the value of `addr_short_i`. While `word_oe_o` is 0, `data_o` is all zeros.
- R6: When `wide_i` is 0 and `addr_short_i` is 0 during a read, `hi_oe_o` is 1 and `byte_o` holds result bits 11 down to 4.
- R7: When `wide_i` is 0 and `addr_short_i` is 1 during a read, `lo_oe_o` is 1 and `byte_o` holds result bits 3 down to 0 in its upper four bits, with its lower four bits forced to 0.
- R8: At most one of `word_oe_o`, `hi_oe_o` and `lo_oe_o` is 1 in any cycle.
- R9: In the stand-alone arrangement (chip enable 1, chip select 0, `addr_short_i` 0, `wide_i` 1), a falling read/convert starts a 12-bit conversion. A high read/convert after the conversion presents the full word.
- R10: The control lines pass through a two-flop synchronizer. `start_o` and the enables change on the third rising clock edge after an input change. `start_o` lasts exactly one cycle.
- R11: If `addr_short_i` changes during a conversion, the flag for that conversion does not change. The next start captures the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_i | input | 1 | Chip enable, active high, asynchronous to clk |
| chip_sel_n_i | input | 1 | Chip select, active low, asynchronous to clk |
| rd_cnv_i | input | 1 | 1 = read, 0 = convert |
| addr_short_i | input | 1 | Length select at a start; byte select during a read |
| wide_i | input | 1 | 1 = full word read, 0 = byte reads |
| busy_i | input | 1 | Sequencer is converting |
| result_i | input | 12 | Conversion result from the sequencer |
| start_o | output | 1 | One-cycle conversion start pulse |
| short_cyc_o | output | 1 | Latched length flag, 1 = 8-bit conversion |
| word_oe_o | output | 1 | Full word presented on data_o |
| hi_oe_o | output | 1 | Upper byte presented on byte_o |
| lo_oe_o | output | 1 | Lower nibble plus zeros presented on byte_o |
| data_o | output | 12 | Word output, zero when not enabled |
| byte_o | output | 8 | Byte-lane output, zero when not enabled |

## Verification
The bound checker checks the following on every cycle:
- that the enables are mutually exclusive;
- that the enables stay low after a busy cycle;
- that no start follows a busy cycle;
- that the length flag moves only with a start;
- that the low-lane padding is zero;
- that idle outputs are zero.

Three behaviours depend on a sequence of events and are shown only by the bench's scenarios:
- which line acts as the last trigger, including three lines changing together;
- that a start condition that arises during a conversion is swallowed and does not start a new one;
- that a length select changed mid-conversion takes effect only at the next start, and that the full synchronizer latency holds.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef struct packed {
        logic ce;
        logic cs_n;
        logic rc;
        logic a0;
        logic wide;
    } host_ctl_t;

    localparam host_ctl_t CTL_IDLE = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0, wide: 1'b1};

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_WORD = 2'd1,
        LANE_HI   = 2'd2,
        LANE_LO   = 2'd3
    } lane_e;

    function automatic logic convert_req(host_ctl_t c);
        return c.ce & ~c.cs_n & ~c.rc;
    endfunction

    function automatic logic read_req(host_ctl_t c);
        return c.ce & ~c.cs_n & c.rc;
    endfunction

    function automatic lane_e pick_lane(host_ctl_t c, logic quiet);
        lane_e l;
        if (!read_req(c) || quiet) l = LANE_OFF;
        else if (c.wide)           l = LANE_WORD;
        else if (c.a0)             l = LANE_LO;
        else                       l = LANE_HI;
        return l;
    endfunction

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
    parameter int unsigned     WIDTH   = 5,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/adc_host_start.sv
module adc_host_start (
    input  logic clk,
    input  logic rst,
    input  logic conv_req_i,
    input  logic len_sel_i,
    input  logic busy_i,
    output logic start_o,
    output logic short_o,
    output logic quiet_o
);
    logic req_q;
    logic pending_q;
    logic fire;

    // rising edge of the combined condition; swallowed while a conversion runs
    assign fire = conv_req_i & ~req_q & ~busy_i & ~pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            pending_q <= 1'b0;
            start_o   <= 1'b0;
            short_o   <= 1'b0;
        end else begin
            req_q   <= conv_req_i;
            start_o <= fire;
            if (fire) begin
                short_o   <= len_sel_i;
                pending_q <= 1'b1;
            end else if (busy_i) begin
                pending_q <= 1'b0;
            end
        end
    end

    // covers the gap between the start pulse and the sequencer raising busy
    assign quiet_o = busy_i | pending_q;
endmodule

// File: rtl/adc_host_read.sv
module adc_host_read
    import adc_host_pkg::*;
#(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_ctl_t         ctl_i,
    input  logic              quiet_i,
    input  logic [RES_W-1:0]  result_i,
    output logic              word_oe_o,
    output logic              hi_oe_o,
    output logic              lo_oe_o,
    output logic [RES_W-1:0]  data_o,
    output logic [LANE_W-1:0] byte_o
);
    localparam int unsigned LO_BITS = RES_W - LANE_W;
    localparam int unsigned PAD     = LANE_W - LO_BITS;

    lane_e             lane_d, lane_q;
    logic [LANE_W-1:0] hi_byte, lo_byte, byte_d;

    assign hi_byte = result_i[RES_W-1 -: LANE_W];

    if (PAD > 0) begin : g_pad
        assign lo_byte = {result_i[LO_BITS-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
        assign lo_byte = result_i[LANE_W-1:0];
    end

    assign lane_d = pick_lane(ctl_i, quiet_i);

    always_comb begin
        unique case (lane_d)
            LANE_HI: byte_d = hi_byte;
            LANE_LO: byte_d = lo_byte;
            default: byte_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= LANE_OFF;
            data_o <= '0;
            byte_o <= '0;
        end else begin
            lane_q <= lane_d;
            data_o <= (lane_d == LANE_WORD) ? result_i : '0;
            byte_o <= byte_d;
        end
    end

    assign word_oe_o = (lane_q == LANE_WORD);
    assign hi_oe_o   = (lane_q == LANE_HI);
    assign lo_oe_o   = (lane_q == LANE_LO);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned LANE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en_i,
    input  logic              chip_sel_n_i,
    input  logic              rd_cnv_i,
    input  logic              addr_short_i,
    input  logic              wide_i,
    input  logic              busy_i,
    input  logic [RES_W-1:0]  result_i,
    output logic              start_o,
    output logic              short_cyc_o,
    output logic              word_oe_o,
    output logic              hi_oe_o,
    output logic              lo_oe_o,
    output logic [RES_W-1:0]  data_o,
    output logic [LANE_W-1:0] byte_o
);
    localparam int unsigned CTL_W = $bits(host_ctl_t);

    host_ctl_t ctl_raw, ctl_s;
    logic      quiet;

    assign ctl_raw = '{ce: chip_en_i, cs_n: chip_sel_n_i, rc: rd_cnv_i,
                       a0: addr_short_i, wide: wide_i};

    adc_host_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(ctl_raw),
        .q_o(ctl_s)
    );

    adc_host_start u_start (
        .clk       (clk),
        .rst       (rst),
        .conv_req_i(convert_req(ctl_s)),
        .len_sel_i (ctl_s.a0),
        .busy_i    (busy_i),
        .start_o   (start_o),
        .short_o   (short_cyc_o),
        .quiet_o   (quiet)
    );

    adc_host_read #(
        .RES_W (RES_W),
        .LANE_W(LANE_W)
    ) u_read (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl_s),
        .quiet_i  (quiet),
        .result_i (result_i),
        .word_oe_o(word_oe_o),
        .hi_oe_o  (hi_oe_o),
        .lo_oe_o  (lo_oe_o),
        .data_o   (data_o),
        .byte_o   (byte_o)
    );
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_i,
    input logic              start_o,
    input logic              short_cyc_o,
    input logic              word_oe_o,
    input logic              hi_oe_o,
    input logic              lo_oe_o,
    input logic [RES_W-1:0]  data_o,
    input logic [LANE_W-1:0] byte_o
);
    localparam int unsigned PAD = LANE_W - (RES_W - LANE_W);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_lanes_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_oe_o, hi_oe_o, lo_oe_o}));

    assert_quiet_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(busy_i)) |-> !(word_oe_o || hi_oe_o || lo_oe_o));

    assert_no_start_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && start_o) |-> !$past(busy_i));

    assert_length_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (seen && !start_o) |-> $stable(short_cyc_o));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    assert_start_excludes_read_R4: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !(word_oe_o || hi_oe_o || lo_oe_o));

    assert_low_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        lo_oe_o |-> (byte_o[PAD-1:0] == '0));

    assert_word_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !word_oe_o |-> (data_o == '0));
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(
    .RES_W (RES_W),
    .LANE_W(LANE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .start_o    (start_o),
    .short_cyc_o(short_cyc_o),
    .word_oe_o  (word_oe_o),
    .hi_oe_o    (hi_oe_o),
    .lo_oe_o    (lo_oe_o),
    .data_o     (data_o),
    .byte_o     (byte_o)
);

// File: tb/adc_host_ctrl_bench.sv
module adc_host_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic ce, cs_n, rc, a0, wide, busy;
    logic [11:0] result, next_res;
    logic start_o, short_cyc_o, word_oe_o, hi_oe_o, lo_oe_o;
    logic [11:0] data_o;
    logic [7:0]  byte_o;

    int checks = 0, errors = 0, starts = 0, cnt = 0;
    bit done = 0;

    adc_host_ctrl u_adc_host_ctrl (
        .clk(clk), .rst(rst), .chip_en_i(ce), .chip_sel_n_i(cs_n), .rd_cnv_i(rc),
        .addr_short_i(a0), .wide_i(wide), .busy_i(busy), .result_i(result),
        .start_o(start_o), .short_cyc_o(short_cyc_o), .word_oe_o(word_oe_o),
        .hi_oe_o(hi_oe_o), .lo_oe_o(lo_oe_o), .data_o(data_o), .byte_o(byte_o)
    );

    // sequencer model: busy for 24 or 16 cycles, then new result
    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; cnt <= 0; result <= 12'h000;
        end else if (busy) begin
            if (cnt == 1) begin busy <= 1'b0; result <= next_res; end
            cnt <= cnt - 1;
        end else if (start_o) begin
            busy <= 1'b1;
            cnt  <= short_cyc_o ? 16 : 24;
        end
    end

    always @(negedge clk) if (!rst && start_o) starts++;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic r, input logic a, input logic w);
        @(negedge clk);
        ce = c; cs_n = s; rc = r; a0 = a; wide = w;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        settle(6);
        while (busy) settle(1);
        settle(4);
    endtask

    function automatic logic [2:0] exp_lanes(input logic c, input logic s, input logic r,
                                             input logic a, input logic w, input logic b);
        if (!(c && !s && r) || b) return 3'b000;
        if (w) return 3'b100;
        return a ? 3'b001 : 3'b010;
    endfunction

    task automatic check_read(input string req);
        logic [2:0]  e;
        logic [11:0] ed;
        logic [7:0]  eb;
        e  = exp_lanes(ce, cs_n, rc, a0, wide, busy);
        ed = e[2] ? result : 12'h000;
        eb = e[1] ? result[11:4] : (e[0] ? {result[3:0], 4'h0} : 8'h00);
        chk({word_oe_o, hi_oe_o, lo_oe_o} == e, req, {word_oe_o, hi_oe_o, lo_oe_o}, e);
        chk(data_o == ed, req, data_o, ed);
        chk(byte_o == eb, req, byte_o, eb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int seed_tap;
        int prev;
        seed_tap = $urandom(32'd2024);
        ce = 0; cs_n = 1; rc = 1; a0 = 0; wide = 1; next_res = 12'hA5C;
        settle(3);
        rst = 0;
        settle(4);

        // reset state
        chk(!start_o && !short_cyc_o && {word_oe_o, hi_oe_o, lo_oe_o} == 3'b000 && starts == 0,
            "R4 reset", {start_o, word_oe_o, hi_oe_o, lo_oe_o}, 0);

        // chip enable low: no start; then chip enable rises last (latency R10)
        drive(0, 0, 0, 0, 1); settle(4);
        chk(starts == 0, "R1 ce low", starts, 0);
        drive(1, 0, 0, 0, 1);
        settle(2); chk(start_o == 0, "R10 edge2", start_o, 0);
        settle(1); chk(start_o == 1, "R10 edge3", start_o, 1);
        settle(1); chk(start_o == 0, "R10 one cycle", start_o, 0);
        chk(short_cyc_o == 0, "R2 12-bit", short_cyc_o, 0);
        wait_idle();
        chk(starts == 1, "R1 ce last", starts, 1);

        // read formats
        drive(1, 0, 1, 0, 1); settle(4); check_read("R5 word");
        chk(data_o == 12'hA5C, "R5 value", data_o, 12'hA5C);
        drive(1, 0, 1, 1, 1); settle(4); check_read("R5 a0 ignored");
        chk(word_oe_o == 1, "R5 a0 ignored", word_oe_o, 1);
        drive(1, 0, 1, 0, 0); settle(4); check_read("R6 high byte");
        chk(byte_o == 8'hA5 && hi_oe_o, "R6 value", byte_o, 8'hA5);
        drive(1, 0, 1, 1, 0); settle(4); check_read("R7 low byte");
        chk(byte_o == 8'hC0 && lo_oe_o, "R7 value", byte_o, 8'hC0);
        drive(1, 1, 1, 1, 0); settle(4); check_read("R4 cs high");
        drive(0, 0, 1, 0, 1); settle(4); check_read("R4 ce low");

        // chip select falls last, 8-bit
        next_res = 12'h3E7;
        drive(1, 1, 0, 1, 1); settle(4);
        chk(starts == 1, "R1 cs high blocks", starts, 1);
        drive(1, 0, 0, 1, 1); settle(4);
        chk(starts == 2, "R1 cs last", starts, 2);
        chk(short_cyc_o == 1, "R2 8-bit", short_cyc_o, 1);
        wait_idle();
        chk(short_cyc_o == 1, "R2 held", short_cyc_o, 1);

        // read/convert falls last; activity during busy
        drive(1, 0, 1, 0, 1); settle(4); check_read("R5 second result");
        next_res = 12'h5A1;
        drive(1, 0, 0, 0, 1); settle(6);
        chk(starts == 3 && busy, "R1 rc last", starts, 3);
        chk(short_cyc_o == 0, "R2 12-bit again", short_cyc_o, 0);
        drive(1, 0, 1, 0, 1); settle(4); check_read("R3 read while busy");
        chk({word_oe_o, hi_oe_o, lo_oe_o} == 3'b000, "R3 no enable", {word_oe_o, hi_oe_o, lo_oe_o}, 0);
        drive(1, 0, 0, 0, 1); settle(4);
        chk(starts == 3, "R3 start ignored", starts, 3);
        drive(1, 0, 0, 1, 1); settle(4);
        chk(short_cyc_o == 0, "R11 length kept", short_cyc_o, 0);
        wait_idle();
        chk(starts == 3, "R3 no late start", starts, 3);
        chk(short_cyc_o == 0, "R11 after busy", short_cyc_o, 0);
        drive(1, 0, 1, 1, 1); settle(4);
        drive(1, 0, 0, 1, 1); settle(6);
        chk(starts == 4 && short_cyc_o == 1, "R11 new value", short_cyc_o, 1);
        wait_idle();

        // all three lines together
        drive(0, 1, 1, 0, 1); settle(4);
        drive(1, 0, 0, 0, 1); settle(6);
        chk(starts == 5, "R1 simultaneous", starts, 5);
        wait_idle();
        chk(starts == 5, "R1 exactly one", starts, 5);

        // stand-alone arrangement
        next_res = 12'h0F3;
        drive(1, 0, 1, 0, 1); settle(4); check_read("R9 read idle");
        drive(1, 0, 0, 0, 1); settle(6);
        chk(starts == 6 && short_cyc_o == 0, "R9 start 12-bit", starts, 6);
        wait_idle();
        chk({word_oe_o, hi_oe_o, lo_oe_o} == 3'b000, "R9 rc low no enable", word_oe_o, 0);
        drive(1, 0, 1, 0, 1); settle(4);
        chk(word_oe_o && data_o == 12'h0F3, "R9 word", data_o, 12'h0F3);

        // random reads
        for (int i = 0; i < 40; i++) begin
            drive(1'($urandom % 2), 1'($urandom % 2), 1'b1, 1'($urandom % 2), 1'($urandom % 2));
            settle(4);
            check_read("R8 random read");
        end

        // random conversions
        for (int i = 0; i < 8; i++) begin
            logic a;
            a = 1'($urandom % 2);
            next_res = 12'($urandom);
            prev = starts;
            drive(1, 0, 1, a, 1); settle(4);
            drive(1, 0, 0, a, 1); settle(6);
            chk(starts == prev + 1, "R1 random start", starts, prev + 1);
            chk(short_cyc_o == a, "R2 random length", short_cyc_o, a);
            wait_idle();
            drive(1, 0, 1, 1'($urandom % 2), 1'($urandom % 2)); settle(4);
            check_read("R6 random result");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule